// File: doc/BRIEF.md
# PLL Bring-Up Sequencer

This block is a hardware state machine that takes three phase-locked loops (main, peripheral and memory) from an unknown condition to running, glitch-free output clocks. One pulse on `start_i` launches a fixed, ordered sequence. First it gates the clock groups and parks every loop in bypass. Then it cycles the bandgap power-down and applies numerator and denominator. It enables the oscillators once the guard time has passed, qualifies lock and pulses output-reset-all. It then updates the output phases one channel at a time. Last, it leaves bypass, clears safe mode, selects the configured clock sources, ungates everything and clears the sticky loss-of-lock flags.

The sequencer waits for the external control logic to go idle after each bypass or safe-mode change. It waits for each phase field to read zero before and after writing it. Microsecond guard intervals come from a cycle count derived from the `CLK_HZ` parameter, rounded up. Configuration values are sampled from static inputs at the step that applies them. Every three-bit per-loop vector uses bit 0 for the main loop, bit 1 for the peripheral loop and bit 2 for the memory loop.

Top module: `pll_bringup_seq`

## Requirements
- R1: Out of reset all clock enables are high, bypass, bandgap power-down, oscillator enable and output reset are all zero, numerator and denominator are zero, both source selects equal `SRC_RST`, and every strobe and `done_o` are low.
- R2: After start, the flash clock enable drops first. On the next cycle the main and memory enables drop, and on the cycle after that the peripheral enable drops. `dbg_clk_en_o` stays high at all times.
- R3: On the cycle after the peripheral gate, all three bypass bits go high. The sequence holds until a cycle in which `busy_i` is low, counting from the cycle after bypass was set.
- R4: The power-down step then asserts bandgap power-down on all loops and clears oscillator enable, numerator and denominator. In the same cycle it returns both source selects to `SRC_RST`. Power-down stays high for BG_US·U+2 cycles, then falls in the same cycle that the configured numerator and denominator appear.
- R5: One cycle after power-down release, `int_div_ld_o` pulses for one cycle. Oscillator enable rises on all three loops GUARD_US·U+2 cycles after the release, together with a one-cycle `ext_div_ld_o` pulse.
- R6: Lock counts only when `lock_i` is 3'b111 on LOCK_RUNS consecutive cycles. Any cycle with a clear bit restarts the count. `cnt_ld_o` pulses on the cycle after the qualifying sample.
- R7: After the counter load, output reset is high on all loops for exactly one cycle while bypass is still all ones.
- R8: Phase channels are served in ascending order. For channel i, the sequencer waits for `phase_nz_i[i]` low, then pulses `phase_we_o[i]` for one cycle with `phase_val_o` holding slice i of `cfg_phase_i`. It then waits for `phase_nz_i[i]` low again.
- R9: After the last phase channel, bypass clears. On the first cycle with `busy_i` low, `safe_clr_o` pulses. On the next cycle with `busy_i` low, the configured source selects are applied. One cycle later all gated enables rise, and one cycle after that `lol_clr_o` pulses.
- R10: `done_o` rises on the cycle after the loss-of-lock pulse and holds until the next accepted start. A start pulse while a sequence is running has no effect on any output.
- R11: The microsecond unit U equals CLK_HZ/1,000,000 rounded up, so each guard interval is at least as long as the requested time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch pulse, accepted when idle or done |
| busy_i | input | 1 | Bypass/control logic still applying a change |
| lock_i | input | 3 | Per-loop lock indications |
| phase_nz_i | input | NPH | Phase field of channel i reads nonzero |
| cfg_numer_i | input | 3·NUM_W | Feedback numerator per loop |
| cfg_denom_i | input | 3·DEN_W | Reference denominator per loop |
| cfg_phase_i | input | NPH·PH_W | Phase value per channel |
| cfg_per_src_i | input | SRC_W | Final peripheral source select |
| cfg_l4_src_i | input | SRC_W | Final interconnect source select |
| bypass_o | output | 3 | Per-loop bypass |
| bgpd_o | output | 3 | Per-loop bandgap power-down |
| vco_en_o | output | 3 | Per-loop oscillator enable |
| outrst_o | output | 3 | Per-loop output-reset-all |
| numer_o | output | 3·NUM_W | Applied numerators |
| denom_o | output | 3·DEN_W | Applied denominators |
| int_div_ld_o | output | 1 | Load internal dividers strobe |
| ext_div_ld_o | output | 1 | Load external dividers strobe |
| cnt_ld_o | output | 1 | Load memory-loop output counters strobe |
| phase_we_o | output | NPH | Phase write strobe per channel |
| phase_val_o | output | PH_W | Phase value being written |
| per_src_o | output | SRC_W | Peripheral source select |
| l4_src_o | output | SRC_W | Interconnect source select |
| flash_clk_en_o | output | 1 | Flash clock gate enable |
| per_clk_en_o | output | 1 | Other peripheral clocks enable |
| main_clk_en_o | output | 1 | Gated main-group clocks enable |
| mem_clk_en_o | output | 1 | Memory-group clocks enable |
| dbg_clk_en_o | output | 1 | Debug, trace and bridge clocks enable |
| safe_clr_o | output | 1 | Safe-mode clear strobe |
| lol_clr_o | output | 1 | Loss-of-lock flag clear strobe |
| done_o | output | 1 | Sequence complete |

## Verification
A state that skips or repeats a step shows up as an output vector that departs from the reference on the very cycle of the wrong transition, because every action is a registered output taken on entry to a step. A timer or rounding fault shifts the fall of bandgap power-down or the rise of oscillator enable by at least one cycle, and this is visible within one guard interval. A lock counter that fails to restart on a miss raises `cnt_ld_o` early, within LOCK_RUNS cycles of the glitch. A phase handshake that ignores `phase_nz_i` pulses `phase_we_o` while the field is still nonzero.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  localparam int NPLL = 3;

  typedef enum logic [4:0] {
    ST_IDLE, ST_GFLASH, ST_GMAIN, ST_GPER, ST_BYP, ST_BYPW,
    ST_VRST, ST_BGW, ST_BGREL, ST_IDIV, ST_GRDW, ST_VON, ST_LOCK,
    ST_CNTLD, ST_ORSET, ST_ORCLR, ST_PHPRE, ST_PHWR, ST_PHPOST,
    ST_UNBYP, ST_UBW, ST_SAFE, ST_SAFW, ST_SRC, ST_UNG, ST_LOL, ST_DONE
  } seq_state_t;

  // Clock cycles per microsecond, rounded up so no interval falls short.
  function automatic int unsigned cycles_per_us(input int unsigned hz);
    longint unsigned h;
    h = longint'(hz);
    return int'((h + 64'd999_999) / 64'd1_000_000);
  endfunction

endpackage

// File: rtl/pllseq_us_timer.sv
module pllseq_us_timer #(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int          US_W   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [US_W-1:0] us_i,
  output logic            tick_o,
  output logic            expired_o
);
  import pllseq_pkg::*;

  localparam int unsigned CPU   = cycles_per_us(CLK_HZ);
  localparam int          PRE_W = (CPU > 1) ? $clog2(CPU) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [US_W-1:0]  left_q;

  assign tick_o    = (left_q != '0) && (pre_q == '0);
  assign expired_o = (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      left_q <= '0;
    end else if (start_i) begin
      pre_q  <= PRE_W'(CPU - 1);
      left_q <= us_i;
    end else if (left_q != '0) begin
      if (pre_q == '0) begin
        pre_q  <= PRE_W'(CPU - 1);
        left_q <= left_q - 1'b1;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pllseq_lock_filter.sv
module pllseq_lock_filter #(
  parameter int RUNS = 10,
  parameter int N    = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [N-1:0] lock_i,
  output logic         locked_o
);
  localparam int CW = $clog2(RUNS + 1);

  logic [CW-1:0] run_q;

  assign locked_o = (run_q == CW'(RUNS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_q <= '0;
    else if (!en_i)       run_q <= '0;
    else if (!(&lock_i))  run_q <= '0;
    else if (!locked_o)   run_q <= run_q + 1'b1;
  end

endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq #(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int          BG_US    = 5,
  parameter int          GUARD_US = 7,
  parameter int          LOCK_RUNS = 10,
  parameter int          NUM_W    = 12,
  parameter int          DEN_W    = 6,
  parameter int          SRC_W    = 2,
  parameter int          SRC_RST  = 0,
  parameter int          NPH      = 4,
  parameter int          PH_W     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    busy_i,
  input  logic [2:0]              lock_i,
  input  logic [NPH-1:0]          phase_nz_i,
  input  logic [3*NUM_W-1:0]      cfg_numer_i,
  input  logic [3*DEN_W-1:0]      cfg_denom_i,
  input  logic [NPH*PH_W-1:0]     cfg_phase_i,
  input  logic [SRC_W-1:0]        cfg_per_src_i,
  input  logic [SRC_W-1:0]        cfg_l4_src_i,
  output logic [2:0]              bypass_o,
  output logic [2:0]              bgpd_o,
  output logic [2:0]              vco_en_o,
  output logic [2:0]              outrst_o,
  output logic [3*NUM_W-1:0]      numer_o,
  output logic [3*DEN_W-1:0]      denom_o,
  output logic                    int_div_ld_o,
  output logic                    ext_div_ld_o,
  output logic                    cnt_ld_o,
  output logic [NPH-1:0]          phase_we_o,
  output logic [PH_W-1:0]         phase_val_o,
  output logic [SRC_W-1:0]        per_src_o,
  output logic [SRC_W-1:0]        l4_src_o,
  output logic                    flash_clk_en_o,
  output logic                    per_clk_en_o,
  output logic                    main_clk_en_o,
  output logic                    mem_clk_en_o,
  output logic                    dbg_clk_en_o,
  output logic                    safe_clr_o,
  output logic                    lol_clr_o,
  output logic                    done_o
);
  import pllseq_pkg::*;

  localparam int US_MAX = (BG_US > GUARD_US) ? BG_US : GUARD_US;
  localparam int US_W   = $clog2(US_MAX + 1);
  localparam int PIW    = (NPH > 1) ? $clog2(NPH) : 1;
  localparam logic [PIW-1:0] PH_LAST = PIW'(NPH - 1);

  seq_state_t     state_q;
  logic [PIW-1:0] ph_idx_q;

  // Named internal events, visible to the bound checker
  logic           tmr_start;
  logic [US_W-1:0] tmr_us;
  logic           us_tick;
  logic           tmr_done;
  logic           lock_ok;
  logic           cur_nz;

  assign tmr_start = (state_q == ST_VRST) || (state_q == ST_BGREL);
  assign tmr_us    = (state_q == ST_VRST) ? US_W'(BG_US) : US_W'(GUARD_US);
  assign cur_nz    = phase_nz_i[ph_idx_q];
  assign dbg_clk_en_o = 1'b1;

  pllseq_us_timer #(.CLK_HZ(CLK_HZ), .US_W(US_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start_i(tmr_start), .us_i(tmr_us),
    .tick_o(us_tick), .expired_o(tmr_done)
  );

  pllseq_lock_filter #(.RUNS(LOCK_RUNS), .N(3)) u_lock (
    .clk(clk), .rst_n(rst_n), .en_i(state_q == ST_LOCK),
    .lock_i(lock_i), .locked_o(lock_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      ph_idx_q       <= '0;
      bypass_o       <= '0;
      bgpd_o         <= '0;
      vco_en_o       <= '0;
      outrst_o       <= '0;
      numer_o        <= '0;
      denom_o        <= '0;
      int_div_ld_o   <= 1'b0;
      ext_div_ld_o   <= 1'b0;
      cnt_ld_o       <= 1'b0;
      phase_we_o     <= '0;
      phase_val_o    <= '0;
      per_src_o      <= SRC_W'(SRC_RST);
      l4_src_o       <= SRC_W'(SRC_RST);
      flash_clk_en_o <= 1'b1;
      per_clk_en_o   <= 1'b1;
      main_clk_en_o  <= 1'b1;
      mem_clk_en_o   <= 1'b1;
      safe_clr_o     <= 1'b0;
      lol_clr_o      <= 1'b0;
      done_o         <= 1'b0;
    end else begin
      int_div_ld_o <= 1'b0;
      ext_div_ld_o <= 1'b0;
      cnt_ld_o     <= 1'b0;
      phase_we_o   <= '0;
      safe_clr_o   <= 1'b0;
      lol_clr_o    <= 1'b0;
      case (state_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          state_q <= ST_GFLASH; flash_clk_en_o <= 1'b0; done_o <= 1'b0;
        end
        ST_GFLASH: begin
          state_q <= ST_GMAIN; main_clk_en_o <= 1'b0; mem_clk_en_o <= 1'b0;
        end
        ST_GMAIN: begin state_q <= ST_GPER; per_clk_en_o <= 1'b0; end
        ST_GPER:  begin state_q <= ST_BYP;  bypass_o <= '1; end
        ST_BYP:   state_q <= ST_BYPW;
        ST_BYPW: if (!busy_i) begin
          state_q   <= ST_VRST;
          bgpd_o    <= '1;
          vco_en_o  <= '0;
          numer_o   <= '0;
          denom_o   <= '0;
          per_src_o <= SRC_W'(SRC_RST);
          l4_src_o  <= SRC_W'(SRC_RST);
        end
        ST_VRST: state_q <= ST_BGW;
        ST_BGW: if (tmr_done) begin
          state_q <= ST_BGREL;
          bgpd_o  <= '0;
          numer_o <= cfg_numer_i;
          denom_o <= cfg_denom_i;
        end
        ST_BGREL: begin state_q <= ST_IDIV; int_div_ld_o <= 1'b1; end
        ST_IDIV:  state_q <= ST_GRDW;
        ST_GRDW: if (tmr_done) begin
          state_q <= ST_VON; vco_en_o <= '1; ext_div_ld_o <= 1'b1;
        end
        ST_VON:  state_q <= ST_LOCK;
        ST_LOCK: if (lock_ok) begin state_q <= ST_CNTLD; cnt_ld_o <= 1'b1; end
        ST_CNTLD: begin state_q <= ST_ORSET; outrst_o <= '1; end
        ST_ORSET: begin state_q <= ST_ORCLR; outrst_o <= '0; ph_idx_q <= '0; end
        ST_ORCLR: state_q <= ST_PHPRE;
        ST_PHPRE: if (!cur_nz) begin
          state_q              <= ST_PHWR;
          phase_we_o[ph_idx_q] <= 1'b1;
          phase_val_o          <= cfg_phase_i[ph_idx_q*PH_W +: PH_W];
        end
        ST_PHWR: state_q <= ST_PHPOST;
        ST_PHPOST: if (!cur_nz) begin
          if (ph_idx_q == PH_LAST) begin
            state_q <= ST_UNBYP; bypass_o <= '0;
          end else begin
            state_q <= ST_PHPRE; ph_idx_q <= ph_idx_q + 1'b1;
          end
        end
        ST_UNBYP: state_q <= ST_UBW;
        ST_UBW:   if (!busy_i) begin state_q <= ST_SAFE; safe_clr_o <= 1'b1; end
        ST_SAFE:  state_q <= ST_SAFW;
        ST_SAFW:  if (!busy_i) begin
          state_q <= ST_SRC; per_src_o <= cfg_per_src_i; l4_src_o <= cfg_l4_src_i;
        end
        ST_SRC: begin
          state_q <= ST_UNG;
          flash_clk_en_o <= 1'b1; per_clk_en_o <= 1'b1;
          main_clk_en_o  <= 1'b1; mem_clk_en_o <= 1'b1;
        end
        ST_UNG: begin state_q <= ST_LOL; lol_clr_o <= 1'b1; end
        ST_LOL: begin state_q <= ST_DONE; done_o <= 1'b1; end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pllseq_checker.sv
module pllseq_checker #(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int          BG_US    = 5,
  parameter int          GUARD_US = 7,
  parameter int          NPH      = 4,
  parameter int          SRC_W    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       bypass_o,
  input logic [2:0]       bgpd_o,
  input logic [2:0]       vco_en_o,
  input logic [2:0]       outrst_o,
  input logic             cnt_ld_o,
  input logic [NPH-1:0]   phase_we_o,
  input logic [NPH-1:0]   phase_nz_i,
  input logic [SRC_W-1:0] per_src_o,
  input logic [SRC_W-1:0] l4_src_o,
  input logic             flash_clk_en_o,
  input logic             per_clk_en_o,
  input logic             main_clk_en_o,
  input logic             mem_clk_en_o,
  input logic             dbg_clk_en_o,
  input logic             safe_clr_o,
  input logic             done_o,
  input logic             lock_ok
);
  import pllseq_pkg::*;

  localparam int unsigned BG_CYC = BG_US * cycles_per_us(CLK_HZ);
  localparam int unsigned GD_CYC = GUARD_US * cycles_per_us(CLK_HZ);

  int unsigned bg_cnt, gd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bg_cnt <= 0;
      gd_cnt <= 0;
    end else begin
      bg_cnt <= (bgpd_o[0]) ? bg_cnt + 1 : 0;
      gd_cnt <= (bgpd_o[0]) ? 0 : ((vco_en_o[0]) ? gd_cnt : gd_cnt + 1);
    end
  end

  // R2
  dbg_on_chk: assert property (@(posedge clk) disable iff (!rst_n) dbg_clk_en_o);
  // R2
  gate_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(per_clk_en_o) |-> (!flash_clk_en_o && !main_clk_en_o && !mem_clk_en_o));
  // R4
  bg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bgpd_o[0]) |-> bg_cnt >= BG_CYC);
  // R5
  guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vco_en_o[0]) |-> gd_cnt >= GD_CYC);
  // R5
  vco_bg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vco_en_o != 3'b000) |-> (bgpd_o == 3'b000));
  // R6
  lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_ld_o) |-> $past(lock_ok));
  // R7
  outrst_byp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outrst_o != 3'b000) |-> (bypass_o == 3'b111) && $past(cnt_ld_o));
  // R8
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase_we_o));
  // R8
  phase_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_we_o != '0) |-> (($past(phase_nz_i) & phase_we_o) == '0));
  // R9
  src_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({per_src_o, l4_src_o}) |-> (!flash_clk_en_o && !per_clk_en_o && !main_clk_en_o));
  // R9
  safe_byp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    safe_clr_o |-> (bypass_o == 3'b000));
  // R10
  done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (bypass_o == 3'b000) && flash_clk_en_o && per_clk_en_o && main_clk_en_o && mem_clk_en_o);

endmodule

bind pll_bringup_seq pllseq_checker #(
  .CLK_HZ(CLK_HZ), .BG_US(BG_US), .GUARD_US(GUARD_US), .NPH(NPH), .SRC_W(SRC_W)
) u_pllseq_chk (
  .clk(clk), .rst_n(rst_n), .bypass_o(bypass_o), .bgpd_o(bgpd_o),
  .vco_en_o(vco_en_o), .outrst_o(outrst_o), .cnt_ld_o(cnt_ld_o),
  .phase_we_o(phase_we_o), .phase_nz_i(phase_nz_i), .per_src_o(per_src_o),
  .l4_src_o(l4_src_o), .flash_clk_en_o(flash_clk_en_o), .per_clk_en_o(per_clk_en_o),
  .main_clk_en_o(main_clk_en_o), .mem_clk_en_o(mem_clk_en_o),
  .dbg_clk_en_o(dbg_clk_en_o), .safe_clr_o(safe_clr_o), .done_o(done_o),
  .lock_ok(lock_ok)
);

// File: tb/tb_pll_bringup_seq.sv
`timescale 1ns/1ps
module tb_pll_bringup_seq;
  localparam int unsigned CLK_HZ = 2_500_000;
  localparam int BG_US = 5, GUARD_US = 7, LOCK_RUNS = 10;
  localparam int NUM_W = 12, DEN_W = 6, SRC_W = 2, SRC_RST = 0, NPH = 4, PH_W = 8;
  localparam int U = (CLK_HZ + 999_999) / 1_000_000;  // R11: rounded-up unit

  logic clk = 0, rst_n = 0, start_i = 0, busy_i = 0;
  logic [2:0] lock_i = '0;
  logic [NPH-1:0] phase_nz_i = '0;
  logic [3*NUM_W-1:0] cfg_numer_i = {12'h3C1, 12'h2B2, 12'h1A3};
  logic [3*DEN_W-1:0] cfg_denom_i = {6'd5, 6'd9, 6'd17};
  logic [NPH*PH_W-1:0] cfg_phase_i = {8'h44, 8'h33, 8'h22, 8'h11};
  logic [SRC_W-1:0] cfg_per_src_i = 2'd2, cfg_l4_src_i = 2'd1;

  logic [2:0] bypass_o, bgpd_o, vco_en_o, outrst_o;
  logic [3*NUM_W-1:0] numer_o;
  logic [3*DEN_W-1:0] denom_o;
  logic int_div_ld_o, ext_div_ld_o, cnt_ld_o;
  logic [NPH-1:0] phase_we_o;
  logic [PH_W-1:0] phase_val_o;
  logic [SRC_W-1:0] per_src_o, l4_src_o;
  logic flash_clk_en_o, per_clk_en_o, main_clk_en_o, mem_clk_en_o, dbg_clk_en_o;
  logic safe_clr_o, lol_clr_o, done_o;

  pll_bringup_seq #(.CLK_HZ(CLK_HZ), .BG_US(BG_US), .GUARD_US(GUARD_US),
    .LOCK_RUNS(LOCK_RUNS), .NUM_W(NUM_W), .DEN_W(DEN_W), .SRC_W(SRC_W),
    .SRC_RST(SRC_RST), .NPH(NPH), .PH_W(PH_W)) dut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
    end
  endtask

  // ---------------- reference model (behavioural, step by step) ----------
  logic [2:0] e_byp = 0, e_bg = 0, e_vco = 0, e_or = 0;
  logic [3*NUM_W-1:0] e_num = 0;
  logic [3*DEN_W-1:0] e_den = 0;
  logic e_idl = 0, e_edl = 0, e_cld = 0, e_safe = 0, e_lol = 0, e_done = 0;
  logic [NPH-1:0] e_we = 0;
  logic [PH_W-1:0] e_pv = 0;
  logic [SRC_W-1:0] e_ps = SRC_RST, e_ls = SRC_RST;
  logic e_fl = 1, e_pe = 1, e_me = 1, e_mm = 1;

  initial begin : model
    int runs;
    wait (rst_n);
    forever begin
      @(posedge clk);
      while (!start_i) @(posedge clk);
      e_fl = 0; e_done = 0;
      @(posedge clk); e_me = 0; e_mm = 0;
      @(posedge clk); e_pe = 0;
      @(posedge clk); e_byp = 3'b111;
      @(posedge clk);
      do @(posedge clk); while (busy_i);
      e_bg = 3'b111; e_vco = 0; e_num = 0; e_den = 0; e_ps = SRC_RST; e_ls = SRC_RST;
      repeat (BG_US * U + 2) @(posedge clk);
      e_bg = 0; e_num = cfg_numer_i; e_den = cfg_denom_i;
      @(posedge clk); e_idl = 1;
      @(posedge clk); e_idl = 0;
      repeat (GUARD_US * U) @(posedge clk);
      e_vco = 3'b111; e_edl = 1;
      @(posedge clk); e_edl = 0;
      runs = 0;
      while (runs < LOCK_RUNS) begin
        @(posedge clk);
        runs = (lock_i == 3'b111) ? runs + 1 : 0;
      end
      @(posedge clk); e_cld = 1;
      @(posedge clk); e_cld = 0; e_or = 3'b111;
      @(posedge clk); e_or = 0;
      for (int i = 0; i < NPH; i++) begin
        if (i == 0) @(posedge clk);
        do @(posedge clk); while (phase_nz_i[i]);
        e_we = '0; e_we[i] = 1'b1; e_pv = cfg_phase_i[i*PH_W +: PH_W];
        @(posedge clk); e_we = '0;
        do @(posedge clk); while (phase_nz_i[i]);
      end
      e_byp = 0;
      @(posedge clk);
      do @(posedge clk); while (busy_i);
      e_safe = 1;
      @(posedge clk); e_safe = 0;
      do @(posedge clk); while (busy_i);
      e_ps = cfg_per_src_i; e_ls = cfg_l4_src_i;
      @(posedge clk); e_fl = 1; e_pe = 1; e_me = 1; e_mm = 1;
      @(posedge clk); e_lol = 1;
      @(posedge clk); e_lol = 0; e_done = 1;
    end
  end

  // ---------------- per-cycle compare and environment ---------------------
  int busy_len = 4, busy_cnt = 0, lk = 0, glitch = 1, pre2 = 0;
  int ph_cnt [NPH];
  logic [2:0] prev_byp = 0;
  int bg_w = 0, bg_last = 0, gd_w = 0, gd_last = 0;

  initial for (int i = 0; i < NPH; i++) ph_cnt[i] = 0;

  always @(negedge clk) begin
    chk("R2", "flash_en", 64'(flash_clk_en_o), 64'(e_fl));
    chk("R2", "main/mem/per en", 64'({main_clk_en_o, mem_clk_en_o, per_clk_en_o}), 64'({e_me, e_mm, e_pe}));
    chk("R2", "dbg_en", 64'(dbg_clk_en_o), 64'd1);
    chk("R3", "bypass", 64'(bypass_o), 64'(e_byp));
    chk("R4 R11", "bgpd", 64'(bgpd_o), 64'(e_bg));
    chk("R4", "numer/denom", 64'({numer_o, denom_o}), 64'({e_num, e_den}));
    chk("R5", "vco_en/ld", 64'({vco_en_o, int_div_ld_o, ext_div_ld_o}), 64'({e_vco, e_idl, e_edl}));
    chk("R6 R7", "cnt_ld/outrst", 64'({cnt_ld_o, outrst_o}), 64'({e_cld, e_or}));
    chk("R8", "phase we/val", 64'({phase_we_o, phase_val_o}), 64'({e_we, e_pv}));
    chk("R9", "src/safe/lol", 64'({per_src_o, l4_src_o, safe_clr_o, lol_clr_o}), 64'({e_ps, e_ls, e_safe, e_lol}));
    chk("R10", "done", 64'(done_o), 64'(e_done));
    // interval measurement for R11
    if (bgpd_o[0]) bg_w++; else begin if (bg_w != 0) bg_last = bg_w; bg_w = 0; end
    if (!bgpd_o[0] && !vco_en_o[0] && !done_o && !flash_clk_en_o) gd_w++;
    else begin if (gd_w != 0 && vco_en_o[0]) gd_last = gd_w; gd_w = 0; end
    // busy from bypass/control logic
    if (bypass_o != prev_byp || safe_clr_o) busy_cnt = busy_len;
    prev_byp = bypass_o;
    busy_i = (busy_cnt > 0);
    if (busy_cnt > 0) busy_cnt--;
    // lock pattern, with an optional miss after a partial run
    if (vco_en_o == 3'b111) lk++; else lk = 0;
    if (lk < 3) lock_i = 3'b000;
    else if (glitch != 0 && lk == 9) lock_i = 3'b101;
    else lock_i = 3'b111;
    // phase field settling
    for (int i = 0; i < NPH; i++) if (phase_we_o[i]) ph_cnt[i] = 3;
    if (pre2 != 0 && phase_we_o[1]) ph_cnt[2] = 8;
    for (int i = 0; i < NPH; i++) begin
      phase_nz_i[i] = (ph_cnt[i] > 0);
      if (ph_cnt[i] > 0) ph_cnt[i]--;
    end
  end

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog: actual hung expected done");
    finish_run();
  end

  task automatic pulse_start;
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
  endtask

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "reset gates", 64'({flash_clk_en_o, per_clk_en_o, main_clk_en_o, mem_clk_en_o}), 64'hF);
    chk("R1", "reset pll ctl", 64'({bypass_o, bgpd_o, vco_en_o, outrst_o}), 64'd0);
    chk("R1", "reset src/done", 64'({per_src_o, l4_src_o, done_o}), 64'({2'(SRC_RST), 2'(SRC_RST), 1'b0}));
    rst_n = 1;
    repeat (4) @(negedge clk);
    // run 1: busy stretches, lock miss, extra start mid-run (R10 ignored)
    pulse_start();
    wait (vco_en_o == 3'b111);
    pulse_start();
    wait (done_o);
    repeat (20) @(negedge clk);
    chk("R10", "done held", 64'(done_o), 64'd1);
    chk("R11", "bgpd width >= BG_US units", 64'(bg_last >= BG_US * U), 64'd1);
    chk("R11", "bgpd width vs rounded time", 64'(bg_last * 1_000_000 >= BG_US * CLK_HZ), 64'd1);
    chk("R11", "guard gap >= GUARD_US units", 64'(gd_last >= GUARD_US * U), 64'd1);
    // run 2: restart from done, no busy, clean lock, channel 2 held nonzero before write
    busy_len = 0; glitch = 0; pre2 = 1;
    cfg_per_src_i = 2'd3; cfg_l4_src_i = 2'd2; cfg_phase_i = {8'hA4, 8'hB3, 8'hC2, 8'hD1};
    pulse_start();
    @(negedge clk);
    chk("R10", "done drops on restart", 64'(done_o), 64'd0);
    wait (done_o);
    repeat (10) @(negedge clk);
    chk("R9", "final sources", 64'({per_src_o, l4_src_o}), 64'({2'd3, 2'd2}));
    finish_run();
  end

endmodule